// File: doc/BRIEF.md
# Outbound Address Translator with Indexed Register Window

This block maps outgoing request addresses from local address space into link address space through a small set of translation windows. Each window has a 64-bit start address, a 32-bit inclusive end address for the low word, a 64-bit destination address, a transaction-type code and an enable bit. All windows share one group of per-window registers on a plain register bus. A selector register picks which window that group currently reads and writes.

For every valid request the block finds the enabled windows that cover the address and picks the one with the lowest number. It returns the address minus the window start plus the window destination, together with the window's type code and number. The result appears one clock after the request. An address that no window covers is passed through unchanged and the hit flag stays low. Only the outbound direction exists. When the selector is pointed at the inbound direction, the per-window registers go inert.

Top module: `ob_xlat`

## Requirements
- R1: After synchronous reset every register reads zero, every window is disabled and `rsp_valid` is low.
- R2: The selector sits at byte offset 0x900. Bit 31 is the direction (1 inbound, 0 outbound) and bits [1:0] are the window number. Both read back as written and every other bit reads zero.
- R3: With the direction outbound, the selected window's registers sit at these offsets: type code in bits [2:0] of 0x904, enable in bit 31 of 0x908, start address low and high words at 0x90C and 0x910, end address low word at 0x914, destination low and high words at 0x918 and 0x91C. All of them read back as written, and bits outside the stored fields (including bit 30 of 0x908) read zero.
- R4: With the direction inbound, the per-window offsets read zero and writes to them change no window.
- R5: A window covers an address when it is enabled, the address's high word equals the start's high word, and the address's low word lies between the start's low word and the end word, both ends included.
- R6: On a hit, `rsp_addr` equals request address − window start + window destination, computed modulo 2^64.
- R7: On a hit, `rsp_type` carries the window's stored type code (memory 0, IO 2, config type 0 = 4, config type 1 = 5) and `rsp_region` carries its number.
- R8: When several enabled windows cover an address, the lowest-numbered one wins.
- R9: On a miss, `rsp_hit` is 0, `rsp_addr` equals the request address, and `rsp_type` and `rsp_region` are 0.
- R10: `rsp_valid` is `req_valid` delayed by exactly one clock. The response reflects the register contents at the request cycle.
- R11: Reads of offsets that are neither the selector nor a per-window register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address bits [11:2] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 64 | Local request address |
| rsp_valid | output | 1 | Response valid, one clock after the request |
| rsp_hit | output | 1 | Some enabled window covered the address |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_type | output | 3 | Transaction-type code of the winning window |
| rsp_region | output | 2 | Number of the winning window |

## Verification
The bench programs four windows with every type code. Two of them overlap, one lies in a nonzero high word, and one ends at the top of its low word. For every window it probes the addresses one below the start, the start, one above the start, one below the end, the end and one above the end, plus the start with a different high word. This separates off-by-one errors in the inclusive bounds, a missing high-word compare and wrong arithmetic on carries. It repeats the sweep after disabling the lower overlapping window, which moves the overlap to the higher one and so tells the priority order apart from a mere enable check. It repeats the sweep again after inbound-direction writes, to show that those writes leave the mapping untouched, and once more after a type change.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 64;
    localparam int TYPE_W  = 3;
    localparam int REG_AW  = 12;

    localparam logic [REG_AW-1:0] OFS_SELECT   = 12'h900;
    localparam logic [REG_AW-1:0] OFS_KIND     = 12'h904;
    localparam logic [REG_AW-1:0] OFS_ENABLE   = 12'h908;
    localparam logic [REG_AW-1:0] OFS_START_LO = 12'h90C;
    localparam logic [REG_AW-1:0] OFS_START_HI = 12'h910;
    localparam logic [REG_AW-1:0] OFS_END_LO   = 12'h914;
    localparam logic [REG_AW-1:0] OFS_DEST_LO  = 12'h918;
    localparam logic [REG_AW-1:0] OFS_DEST_HI  = 12'h91C;

    localparam int DIR_BIT = 31;
    localparam int EN_BIT  = 31;

    typedef enum logic [TYPE_W-1:0] {
        KIND_MEM  = 3'd0,
        KIND_IO   = 3'd2,
        KIND_CFG0 = 3'd4,
        KIND_CFG1 = 3'd5
    } xkind_e;

    typedef struct packed {
        logic                en;
        logic [TYPE_W-1:0]   kind;
        logic [ADDR_W-1:0]   start;
        logic [WORD_W-1:0]   end_lo;
        logic [ADDR_W-1:0]   dest;
    } window_t;

    function automatic logic window_covers(window_t w, logic [ADDR_W-1:0] a);
        return w.en
            && (a[ADDR_W-1:WORD_W] == w.start[ADDR_W-1:WORD_W])
            && (a[WORD_W-1:0] >= w.start[WORD_W-1:0])
            && (a[WORD_W-1:0] <= w.end_lo);
    endfunction

    function automatic logic [ADDR_W-1:0] window_map(window_t w, logic [ADDR_W-1:0] a);
        return a - w.start + w.dest;
    endfunction
endpackage

// File: rtl/xlat_regfile.sv
module xlat_regfile
    import xlat_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int IDX_W       = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [REG_AW-1:2]            addr,
    input  logic [WORD_W-1:0]            wdata,
    output logic [WORD_W-1:0]            rdata,
    output window_t [NUM_REGIONS-1:0]    windows
);
    localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_REGIONS);

    logic                 sel_inbound;
    logic [IDX_W-1:0]     sel_index;
    window_t [NUM_REGIONS-1:0] win_q;
    logic [REG_AW-1:0]    ofs;
    logic                 sel_ok;
    window_t              cur;

    assign ofs    = {addr, 2'b00};
    assign sel_ok = !sel_inbound && ({1'b0, sel_index} < NUM_L);
    assign cur    = sel_ok ? win_q[sel_index] : '0;
    assign windows = win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_inbound <= 1'b0;
            sel_index   <= '0;
            win_q       <= '0;
        end else if (wr_en) begin
            if (ofs == OFS_SELECT) begin
                sel_inbound <= wdata[DIR_BIT];
                sel_index   <= wdata[IDX_W-1:0];
            end else if (sel_ok) begin
                case (ofs)
                    OFS_KIND:     win_q[sel_index].kind   <= wdata[TYPE_W-1:0];
                    OFS_ENABLE:   win_q[sel_index].en     <= wdata[EN_BIT];
                    OFS_START_LO: win_q[sel_index].start[WORD_W-1:0]      <= wdata;
                    OFS_START_HI: win_q[sel_index].start[ADDR_W-1:WORD_W] <= wdata;
                    OFS_END_LO:   win_q[sel_index].end_lo <= wdata;
                    OFS_DEST_LO:  win_q[sel_index].dest[WORD_W-1:0]       <= wdata;
                    OFS_DEST_HI:  win_q[sel_index].dest[ADDR_W-1:WORD_W]  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_SELECT: begin
                rdata[DIR_BIT]     = sel_inbound;
                rdata[IDX_W-1:0]   = sel_index;
            end
            OFS_KIND:     rdata[TYPE_W-1:0] = cur.kind;
            OFS_ENABLE:   rdata[EN_BIT]     = cur.en;
            OFS_START_LO: rdata = cur.start[WORD_W-1:0];
            OFS_START_HI: rdata = cur.start[ADDR_W-1:WORD_W];
            OFS_END_LO:   rdata = cur.end_lo;
            OFS_DEST_LO:  rdata = cur.dest[WORD_W-1:0];
            OFS_DEST_HI:  rdata = cur.dest[ADDR_W-1:WORD_W];
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int NUM_REGIONS = 4
) (
    input  window_t [NUM_REGIONS-1:0]              windows,
    input  logic [ADDR_W-1:0]                      addr,
    output logic [NUM_REGIONS-1:0]                 cover_vec,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     mapped
);
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        assign cover_vec[g] = window_covers(windows[g], addr);
        assign mapped[g]    = window_map(windows[g], addr);
    end
endmodule

// File: rtl/xlat_prio.sv
module xlat_prio #(
    parameter int NUM_REGIONS = 4,
    parameter int IDX_W       = 2
) (
    input  logic [NUM_REGIONS-1:0] req_vec,
    output logic [NUM_REGIONS-1:0] grant,
    output logic [IDX_W-1:0]       index,
    output logic                   any
);
    always_comb begin
        grant = '0;
        index = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (req_vec[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                index    = IDX_W'(i);
            end
        end
    end
    assign any = |req_vec;
endmodule

// File: rtl/ob_xlat.sv
module ob_xlat
    import xlat_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [REG_AW-1:2]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [ADDR_W-1:0]    rsp_addr,
    output logic [TYPE_W-1:0]    rsp_type,
    output logic [IDX_W-1:0]     rsp_region
);
    window_t [NUM_REGIONS-1:0]            windows;
    logic [NUM_REGIONS-1:0]               cover_vec;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0]   mapped;
    logic [NUM_REGIONS-1:0]               grant;
    logic [IDX_W-1:0]                     win_idx;
    logic                                 any_hit;
    logic [ADDR_W-1:0]                    sel_addr;
    logic [TYPE_W-1:0]                    sel_kind;

    xlat_regfile #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .windows(windows)
    );

    xlat_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
        .windows(windows), .addr(req_addr),
        .cover_vec(cover_vec), .mapped(mapped)
    );

    xlat_prio #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_prio (
        .req_vec(cover_vec), .grant(grant), .index(win_idx), .any(any_hit)
    );

    always_comb begin
        sel_addr = any_hit ? '0 : req_addr;
        sel_kind = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            sel_addr = sel_addr | ({ADDR_W{grant[i]}} & mapped[i]);
            sel_kind = sel_kind | ({TYPE_W{grant[i]}} & windows[i].kind);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_addr   <= '0;
            rsp_type   <= '0;
            rsp_region <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit    <= any_hit;
                rsp_addr   <= sel_addr;
                rsp_type   <= sel_kind;
                rsp_region <= win_idx;
            end
        end
    end
endmodule

// File: rtl/ob_xlat_chk.sv
module ob_xlat_chk
    import xlat_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int IDX_W       = 2
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         reg_we,
    input logic [REG_AW-1:2]            reg_addr,
    input logic [WORD_W-1:0]            reg_wdata,
    input logic                         req_valid,
    input logic [ADDR_W-1:0]            req_addr,
    input logic                         rsp_valid,
    input logic                         rsp_hit,
    input logic [ADDR_W-1:0]            rsp_addr,
    input logic [IDX_W-1:0]             rsp_region,
    input window_t [NUM_REGIONS-1:0]    windows,
    input logic [NUM_REGIONS-1:0]       grant
);
    logic                    inb_seen;
    logic [NUM_REGIONS-1:0]  en_vec;
    logic [NUM_REGIONS-1:0]  en_prev;
    logic [REG_AW-1:0]       ofs;
    logic                    win_ofs;

    assign ofs     = {reg_addr, 2'b00};
    assign win_ofs = (ofs >= OFS_KIND) && (ofs <= OFS_DEST_HI);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_en
        assign en_vec[g] = windows[g].en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inb_seen <= 1'b0;
            en_prev  <= '0;
        end else begin
            en_prev <= en_vec;
            if (reg_we && ofs == OFS_SELECT) inb_seen <= reg_wdata[DIR_BIT];
        end
    end

    // R1
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!rsp_valid && windows == '0));

    // R10
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_idle_follows_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R9
    assert_miss_passthrough_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && grant == '0) |=> (!rsp_hit && rsp_addr == $past(req_addr)));

    // R8
    assert_single_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5
    assert_hit_enabled_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> en_prev[rsp_region]);

    // R4
    assert_inbound_inert_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_we && inb_seen && win_ofs) |=> $stable(windows));
endmodule

bind ob_xlat ob_xlat_chk #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
    .rsp_region(rsp_region), .windows(windows), .grant(grant)
);

// File: tb/tb_ob_xlat.sv
module tb_ob_xlat;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [63:0] rsp_addr;
    logic [2:0]  rsp_type;
    logic [1:0]  rsp_region;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic        m_en  [4];
    logic [2:0]  m_ty  [4];
    logic [63:0] m_base[4];
    logic [31:0] m_lim [4];
    logic [63:0] m_tgt [4];

    ob_xlat #(.NUM_REGIONS(4)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_addr(rsp_addr), .rsp_type(rsp_type), .rsp_region(rsp_region)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] ofs, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ofs[11:2]; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(logic [11:0] ofs, logic [31:0] exp, string req);
        @(negedge clk);
        reg_addr = ofs[11:2];
        #1;
        check(req, {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    task automatic prog(int i, logic [2:0] ty, logic [63:0] b, logic [31:0] lim,
                        logic [63:0] t, logic en);
        wr(12'h900, i);
        wr(12'h904, {29'h1FFF_FFFF, ty});
        wr(12'h90C, b[31:0]);
        wr(12'h910, b[63:32]);
        wr(12'h914, lim);
        wr(12'h918, t[31:0]);
        wr(12'h91C, t[63:32]);
        wr(12'h908, {en, 31'h7FFF_FFFF});
        m_en[i] = en; m_ty[i] = ty; m_base[i] = b; m_lim[i] = lim; m_tgt[i] = t;
    endtask

    function automatic void model(input logic [63:0] a, output logic h,
                                  output logic [63:0] xa, output logic [2:0] ty,
                                  output logic [1:0] rg);
        h = 1'b0; xa = a; ty = 3'd0; rg = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (m_en[i] && a[63:32] == m_base[i][63:32] &&
                a[31:0] >= m_base[i][31:0] && a[31:0] <= m_lim[i]) begin
                h = 1'b1; xa = a - m_base[i] + m_tgt[i]; ty = m_ty[i]; rg = 2'(i);
            end
        end
    endfunction

    task automatic probe(logic [63:0] a, string tag);
        logic h; logic [63:0] xa; logic [2:0] ty; logic [1:0] rg;
        model(a, h, xa, ty, rg);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({"R10 valid ", tag}, {63'h0, rsp_valid}, 64'h1);
        check(h ? {"R5 hit ", tag} : {"R9 miss ", tag}, {63'h0, rsp_hit}, {63'h0, h});
        check(h ? {"R6 addr ", tag} : {"R9 addr ", tag}, rsp_addr, xa);
        check({"R7 type ", tag}, {61'h0, rsp_type}, {61'h0, ty});
        check({"R8 region ", tag}, {62'h0, rsp_region}, {62'h0, rg});
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < 4; i++) begin
            logic [63:0] endp;
            endp = {m_base[i][63:32], m_lim[i]};
            probe(m_base[i] - 64'd1, tag);
            probe(m_base[i], tag);
            probe(m_base[i] + 64'd1, tag);
            probe(endp - 64'd1, tag);
            probe(endp, tag);
            probe(endp + 64'd1, tag);
            probe({m_base[i][63:32] + 32'd1, m_base[i][31:0]}, tag);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_en[i] = 0; m_ty[i] = 0; m_base[i] = 0; m_lim[i] = 0; m_tgt[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
        rd_chk(12'h900, 32'h0, "R1 selector");
        for (int i = 0; i < 4; i++) begin
            wr(12'h900, i);
            rd_chk(12'h908, 32'h0, "R1 enable");
            rd_chk(12'h90C, 32'h0, "R1 start");
        end
        probe(64'h0, "R1 all disabled");

        // R2: selector masking
        wr(12'h900, 32'h7FFF_FFF2);
        rd_chk(12'h900, 32'h0000_0002, "R2 selector mask");

        prog(0, 3'd0, 64'h0000_0001_0000_0000, 32'h0000_0FFF, 64'h0000_0000_8000_0000, 1'b1);
        prog(1, 3'd4, 64'h0000_0000_4000_0000, 32'h4000_00FF, 64'h0, 1'b1);
        prog(2, 3'd2, 64'h0000_0000_4000_0080, 32'h4000_01FF, 64'h0000_0010_0000_0000, 1'b1);
        prog(3, 3'd5, 64'h0000_0002_FFFF_F000, 32'hFFFF_FFFF, 64'h1234_0000_0000_0000, 1'b1);

        // R3: readback of window 2 fields
        wr(12'h900, 32'h2);
        rd_chk(12'h900, 32'h2, "R2 selector");
        rd_chk(12'h904, 32'h2, "R3 type");
        rd_chk(12'h908, 32'h8000_0000, "R3 enable");
        rd_chk(12'h90C, 32'h4000_0080, "R3 start lo");
        rd_chk(12'h910, 32'h0, "R3 start hi");
        rd_chk(12'h914, 32'h4000_01FF, "R3 end");
        rd_chk(12'h918, 32'h0, "R3 dest lo");
        rd_chk(12'h91C, 32'h10, "R3 dest hi");

        // R11: unmapped offsets
        rd_chk(12'h000, 32'h0, "R11 offset 000");
        rd_chk(12'h8FC, 32'h0, "R11 offset 8FC");
        rd_chk(12'h920, 32'h0, "R11 offset 920");

        sweep("R5 R8 base");

        // R10: no request, no response
        @(negedge clk);
        check("R10 idle", {63'h0, rsp_valid}, 64'h0);

        // R8/R5: disable window 1, overlap goes to window 2
        wr(12'h900, 32'h1);
        wr(12'h908, 32'h0);
        m_en[1] = 1'b0;
        sweep("R5 R8 disabled");

        // R4: inbound direction is inert
        wr(12'h900, 32'h8000_0001);
        rd_chk(12'h900, 32'h8000_0001, "R2 inbound");
        rd_chk(12'h90C, 32'h0, "R4 read zero");
        wr(12'h90C, 32'hDEAD_BEEF);
        wr(12'h908, 32'h8000_0000);
        wr(12'h904, 32'h5);
        wr(12'h900, 32'h1);
        rd_chk(12'h90C, 32'h4000_0000, "R4 start kept");
        rd_chk(12'h908, 32'h0, "R4 enable kept");
        rd_chk(12'h904, 32'h4, "R4 type kept");
        sweep("R4 after inbound");

        // R7: type change on window 0
        wr(12'h900, 32'h0);
        wr(12'h904, 32'h1);
        m_ty[0] = 3'd1;
        sweep("R7 type change");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule